// File: doc/BRIEF.md
# Vectored Peripheral Interrupt Controller

The controller gathers level-sensitive interrupt requests from up to 32 peripheral sources and drives one interrupt line to a host processor. Software reaches it through a small register port with four word registers: configuration, mask, in-service and vector. The configuration register holds a global enable and a field that names the source with the top priority. The other sources follow in ascending index order from that source and wrap around past the highest index.

To service an interrupt, the host writes 1 to the acknowledge bit of the vector register. On that write the controller latches the best eligible source, sets its in-service bit and keeps its 5-bit code in bits [15:11] until the next acknowledge. The host then reads the vector register to get the code. While a source is in service, sources of the same or lower priority cannot raise the line. Writing 1 to a bit of the in-service register clears it, which ends that interrupt. If no eligible source remains when the acknowledge arrives, for example because the request was dropped or masked after the line rose, the code latched is 0. Source index 0 is reserved for this error code and its request input is never used.

Register addresses (reg_addr_i): 0 = configuration (bit 0 global enable, bits [17:13] top-priority source), 1 = mask, 2 = in-service, 3 = vector (write bit 0 = acknowledge, read bits [15:11] = code). All other read bits are 0.

Top module: `pic_vec`

## Requirements
- R1: After reset, irq_o is 0 and reads of the configuration, mask, in-service and vector registers all return 0.
- R2: irq_o stays 0 while configuration bit 0 (global enable) is 0, even when an unmasked source is pending; once the enable is set, a pending eligible source raises irq_o.
- R3: A source with mask bit 0 neither raises irq_o nor gets picked on acknowledge; mask bit 1 enables it.
- R4: A write to address 3 with bit 0 set latches the highest-priority eligible source. Its code reads back in vector bits [15:11] and its in-service bit becomes 1. irq_o is registered: it reflects the state one clock later.
- R5: Priority rank of source s is (s - H) mod 32, where H is configuration bits [17:13]; rank 0 is the highest priority.
- R6: While in-service bits are set, only pending unmasked sources ranked strictly above the best in-service source raise irq_o or get picked on acknowledge.
- R7: Writing the in-service register clears each bit written as 1 and leaves the bits written as 0 unchanged.
- R8: An acknowledge with no eligible source latches code 0 and leaves the in-service register unchanged.
- R9: The latched code does not change until the next acknowledge, whatever the sources do.
- R10: Request input 0 is ignored. It never raises irq_o and is never picked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register address |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data for reg_addr_i (combinational) |
| src_i | input | NUM_SRC | Level-sensitive interrupt requests |
| irq_o | output | 1 | Interrupt line to host |

## Verification
The bench builds the block with the default of 32 sources, so every 5-bit code is usable. That brings the priority wrap between source 31 and source 1 within reach, and also the top code 31 and the reserved index 0. Table rows vary the priority base and the mask against pairs of competing requests. Directed sequences cover nested service with in-service blocking, the release of a waiting source by end-of-interrupt, and the race in which a request vanishes before acknowledge.

// File: rtl/pic_vec_pkg.sv
package pic_vec_pkg;
  localparam logic [1:0] ADDR_CFG  = 2'd0;
  localparam logic [1:0] ADDR_MASK = 2'd1;
  localparam logic [1:0] ADDR_ISR  = 2'd2;
  localparam logic [1:0] ADDR_VEC  = 2'd3;
  localparam int CFG_EN_BIT = 0;
  localparam int CFG_HP_LSB = 13;
  localparam int VEC_LSB    = 11;
  localparam int VEC_W      = 5;
endpackage

// File: rtl/pic_vec_prio.sv
// Rotating find-first: lowest (idx - base) mod N among set request bits.
module pic_vec_prio #(
  parameter int N  = 32,
  parameter int IW = $clog2(N)
) (
  input  logic [N-1:0]  req_i,
  input  logic [IW-1:0] base_i,
  output logic          valid_o,
  output logic [IW-1:0] idx_o
);
  always_comb begin
    valid_o = 1'b0;
    idx_o   = '0;
    for (int k = N - 1; k >= 0; k--) begin
      int s;
      s = (int'(base_i) + k) % N;
      if (req_i[s]) begin
        valid_o = 1'b1;
        idx_o   = IW'(s);
      end
    end
  end
endmodule

// File: rtl/pic_vec_elig.sv
// Sources pending, unmasked and ranked above the current in-service level.
module pic_vec_elig #(
  parameter int N  = 32,
  parameter int IW = $clog2(N)
) (
  input  logic [N-1:0]  req_i,
  input  logic [N-1:0]  mask_i,
  input  logic [IW-1:0] base_i,
  input  logic          isr_act_i,
  input  logic [IW-1:0] isr_idx_i,
  output logic [N-1:0]  elig_o
);
  logic [IW:0] lvl;
  logic [IW:0] isr_rank;

  assign isr_rank = (IW+1)'((int'(isr_idx_i) - int'(base_i) + N) % N);
  assign lvl      = isr_act_i ? isr_rank : (IW+1)'(N);

  for (genvar g = 0; g < N; g++) begin : g_src
    if (g == 0) begin : g_rsvd
      // index 0 carries the error code, its request never counts
      assign elig_o[g] = req_i[g] & mask_i[g] & 1'b0;
    end else begin : g_live
      logic [IW:0] rank;
      assign rank      = (IW+1)'((g - int'(base_i) + N) % N);
      assign elig_o[g] = req_i[g] & mask_i[g] & (rank < lvl);
    end
  end
endmodule

// File: rtl/pic_vec.sv
module pic_vec
  import pic_vec_pkg::*;
#(
  parameter int NUM_SRC = 32
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               reg_we_i,
  input  logic [1:0]         reg_addr_i,
  input  logic [31:0]        reg_wdata_i,
  output logic [31:0]        reg_rdata_o,
  input  logic [NUM_SRC-1:0] src_i,
  output logic               irq_o
);
  localparam int IW = $clog2(NUM_SRC);

  logic               en_q;
  logic [IW-1:0]      hp_q;
  logic [NUM_SRC-1:0] mask_q;
  logic [NUM_SRC-1:0] isr_q;
  logic [IW-1:0]      vec_q;
  logic               irq_q;

  logic               isr_act;
  logic [IW-1:0]      isr_idx;
  logic [NUM_SRC-1:0] elig;
  logic               cand_valid;
  logic [IW-1:0]      cand_idx;
  logic               ack;

  pic_vec_prio #(.N(NUM_SRC), .IW(IW)) u_isr_top (
    .req_i  (isr_q),
    .base_i (hp_q),
    .valid_o(isr_act),
    .idx_o  (isr_idx)
  );

  pic_vec_elig #(.N(NUM_SRC), .IW(IW)) u_elig (
    .req_i    (src_i),
    .mask_i   (mask_q),
    .base_i   (hp_q),
    .isr_act_i(isr_act),
    .isr_idx_i(isr_idx),
    .elig_o   (elig)
  );

  pic_vec_prio #(.N(NUM_SRC), .IW(IW)) u_cand (
    .req_i  (elig),
    .base_i (hp_q),
    .valid_o(cand_valid),
    .idx_o  (cand_idx)
  );

  assign ack = reg_we_i && (reg_addr_i == ADDR_VEC) && reg_wdata_i[0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q   <= 1'b0;
      hp_q   <= '0;
      mask_q <= '0;
      isr_q  <= '0;
      vec_q  <= '0;
      irq_q  <= 1'b0;
    end else begin
      irq_q <= en_q & cand_valid;
      if (reg_we_i) begin
        unique case (reg_addr_i)
          ADDR_CFG: begin
            en_q <= reg_wdata_i[CFG_EN_BIT];
            hp_q <= reg_wdata_i[CFG_HP_LSB +: IW];
          end
          ADDR_MASK: mask_q <= reg_wdata_i[NUM_SRC-1:0];
          ADDR_ISR:  isr_q  <= isr_q & ~reg_wdata_i[NUM_SRC-1:0];
          ADDR_VEC: begin
            if (ack) begin
              if (cand_valid) begin
                vec_q           <= cand_idx;
                isr_q[cand_idx] <= 1'b1;
              end else begin
                vec_q <= '0;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    reg_rdata_o = '0;
    unique case (reg_addr_i)
      ADDR_CFG: begin
        reg_rdata_o[CFG_EN_BIT]         = en_q;
        reg_rdata_o[CFG_HP_LSB +: IW]   = hp_q;
      end
      ADDR_MASK: reg_rdata_o[NUM_SRC-1:0] = mask_q;
      ADDR_ISR:  reg_rdata_o[NUM_SRC-1:0] = isr_q;
      ADDR_VEC:  reg_rdata_o[VEC_LSB +: VEC_W] = VEC_W'(vec_q);
      default: ;
    endcase
  end

  assign irq_o = irq_q;
endmodule

// File: rtl/pic_vec_checker.sv
module pic_vec_checker #(
  parameter int NUM_SRC = 32,
  parameter int IW      = $clog2(NUM_SRC)
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               reg_we_i,
  input logic [1:0]         reg_addr_i,
  input logic [31:0]        reg_wdata_i,
  input logic               irq_o,
  input logic               en_i,
  input logic               cand_valid_i,
  input logic [NUM_SRC-1:0] isr_i,
  input logic [IW-1:0]      vec_i
);
  logic ack;
  logic isr_wr;
  assign ack    = reg_we_i && (reg_addr_i == 2'd3) && reg_wdata_i[0];
  assign isr_wr = reg_we_i && (reg_addr_i == 2'd2);

  assert_irq_gated_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> !irq_o);

  assert_ack_sets_one_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack && cand_valid_i) |=> ($countones(isr_i) == $past($countones(isr_i)) + 1));

  assert_w1c_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    isr_wr |=> ((isr_i & $past(reg_wdata_i[NUM_SRC-1:0])) == '0));

  assert_err_vec_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack && !cand_valid_i) |=> (vec_i == '0) && $stable(isr_i));

  assert_vec_frozen_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ack |=> $stable(vec_i));

  assert_src0_idle_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !isr_i[0]);
endmodule

bind pic_vec pic_vec_checker #(.NUM_SRC(NUM_SRC)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .reg_we_i    (reg_we_i),
  .reg_addr_i  (reg_addr_i),
  .reg_wdata_i (reg_wdata_i),
  .irq_o       (irq_o),
  .en_i        (en_q),
  .cand_valid_i(cand_valid),
  .isr_i       (isr_q),
  .vec_i       (vec_q)
);

// File: tb/pic_vec_tb.sv
`timescale 1ns/1ps
module pic_vec_tb;
  localparam int N = 32;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        we = 1'b0;
  logic [1:0]  addr = 2'd0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [N-1:0] src = '0;
  logic        irq;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  always #2 clk = ~clk;

  pic_vec #(.NUM_SRC(N)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(we), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .src_i(src), .irq_o(irq)
  );

  typedef struct packed {
    logic [31:0] src;
    logic [31:0] msk;
    logic [4:0]  hp;
    logic        irq;
    logic [4:0]  vec;
  } row_t;

  localparam int NROW = 8;
  localparam row_t TBL [NROW] = '{
    '{32'h0000_0010, 32'hFFFF_FFFF, 5'd0,  1'b1, 5'd4},
    '{32'h0000_0210, 32'hFFFF_FFFF, 5'd5,  1'b1, 5'd9},
    '{32'h0000_0210, 32'hFFFF_FFFF, 5'd3,  1'b1, 5'd4},
    '{32'h0000_0210, 32'hFFFF_FFEF, 5'd3,  1'b1, 5'd9},
    '{32'h8000_0002, 32'hFFFF_FFFF, 5'd2,  1'b1, 5'd31},
    '{32'h8000_0002, 32'hFFFF_FFFF, 5'd1,  1'b1, 5'd1},
    '{32'h0000_0001, 32'hFFFF_FFFF, 5'd0,  1'b0, 5'd0},
    '{32'h0000_0080, 32'h0000_0000, 5'd0,  1'b0, 5'd0}
  };

  function automatic string row_tag(int i);
    case (i)
      0: return "R4";
      1, 2, 4, 5: return "R5";
      3: return "R3";
      6: return "R10";
      default: return "R3";
    endcase
  endfunction

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    we = 1'b0; wdata = '0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk);
    addr = a;
    #1 d = rdata;
  endtask

  task automatic settle();
    repeat (2) @(negedge clk);
  endtask

  task automatic ack_vec(output logic [4:0] v);
    logic [31:0] r;
    wr(2'd3, 32'h1);
    rd(2'd3, r);
    v = r[15:11];
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] r;
    logic [4:0]  v;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset state
    chk({31'b0, irq}, 32'h0, "R1 irq");
    rd(2'd0, r); chk(r, 32'h0, "R1 cfg");
    rd(2'd1, r); chk(r, 32'h0, "R1 mask");
    rd(2'd2, r); chk(r, 32'h0, "R1 isr");
    rd(2'd3, r); chk(r, 32'h0, "R1 vec");

    // R2: global enable gates the line
    wr(2'd1, 32'hFFFF_FFFF);
    src = 32'h0000_0020;
    settle();
    chk({31'b0, irq}, 32'h0, "R2 disabled");
    wr(2'd0, 32'h1);
    settle();
    chk({31'b0, irq}, 32'h1, "R2 enabled");
    src = '0;

    // table walk: priority, mask, reserved source
    for (int i = 0; i < NROW; i++) begin
      wr(2'd2, 32'hFFFF_FFFF);
      wr(2'd0, (32'(TBL[i].hp) << 13) | 32'h1);
      wr(2'd1, TBL[i].msk);
      src = TBL[i].src;
      settle();
      chk({31'b0, irq}, {31'b0, TBL[i].irq}, {row_tag(i), " irq"});
      ack_vec(v);
      chk({27'b0, v}, {27'b0, TBL[i].vec}, {row_tag(i), " vec"});
      rd(2'd2, r);
      chk(r, (TBL[i].vec == 5'd0) ? 32'h0 : (32'h1 << TBL[i].vec), {row_tag(i), " isr"});
      src = '0;
    end

    // R6: nested service with hp=0
    wr(2'd2, 32'hFFFF_FFFF);
    wr(2'd0, 32'h1);
    wr(2'd1, 32'hFFFF_FFFF);
    src = 32'h0000_0010;
    settle();
    ack_vec(v);
    chk({27'b0, v}, 32'd4, "R4 first ack");
    src = 32'h0000_0210;
    settle();
    chk({31'b0, irq}, 32'h0, "R6 lower blocked");
    src = 32'h0000_0214;
    settle();
    chk({31'b0, irq}, 32'h1, "R6 higher preempts");
    ack_vec(v);
    chk({27'b0, v}, 32'd2, "R6 nested vec");
    rd(2'd2, r); chk(r, 32'h0000_0014, "R6 nested isr");

    // R9: code frozen while sources change
    src = 32'h0000_0002;
    settle();
    rd(2'd3, r); chk({27'b0, r[15:11]}, 32'd2, "R9 frozen");

    // R7: write-one-to-clear
    src = 32'h0000_0200;
    wr(2'd2, 32'h0000_0200);
    rd(2'd2, r); chk(r, 32'h0000_0014, "R7 zero bits kept");
    wr(2'd2, 32'h0000_0004);
    rd(2'd2, r); chk(r, 32'h0000_0010, "R7 bit cleared");
    settle();
    chk({31'b0, irq}, 32'h0, "R6 still blocked");
    wr(2'd2, 32'h0000_0010);
    settle();
    chk({31'b0, irq}, 32'h1, "R7 eoi releases");

    // R8: request vanishes before acknowledge
    src = '0;
    ack_vec(v);
    chk({27'b0, v}, 32'd0, "R8 error vec");
    rd(2'd2, r); chk(r, 32'h0, "R8 isr unchanged");

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule